// File: doc/BRIEF.md
# Multi-line wake-up source controller

This block watches up to eight wake-up lines. Each line picks one of four candidate signals through a 2-bit selector. It synchronises the chosen candidate, looks for an edge of the programmed direction and latches a per-line flag. Software programs three configuration registers (line enable, edge polarity, source select) and reads a status register. It clears flags by writing a mask to a separate clear register, normally the status value it has just read. The OR of all flags is a wake-up request, and an interrupt follows that request one clock later.

Each line is run by a small state machine with the states LN_OFF, LN_PRIME and LN_WATCH. Setting the enable moves LN_OFF to LN_PRIME. LN_PRIME always moves on to LN_WATCH after one cycle, unless the line is disabled or its configuration changes again. A change of that line's polarity or select field moves LN_WATCH back to LN_PRIME. Clearing the enable moves any state to LN_OFF. Edges count only in LN_WATCH, so a line never flags on the cycle in which its source or polarity has just changed. A parameter mask decides which lines are built. A line that is not built reads zero in every register and never flags.

Top module: `wkup_line_ctrl`

## Requirements
- R1: After reset all registers read zero, all flags are zero, and wake_req and wake_irq are low.
- R2: On an enabled line with polarity 0, a rising edge of the selected candidate sets that line's flag. The candidate goes through two synchroniser flops and one edge register, so the flag is set at the third rising clock edge after the candidate changes.
- R3: With polarity 1 a line flags on a falling edge of its selected candidate and ignores the rising edge.
- R4: Line n with select value s watches wake_cand[4n+s]. Edges on the other candidates of that line set no flag.
- R5: A disabled line sets no flag. Clearing a line's enable bit leaves its polarity and select fields and its existing flag unchanged.
- R6: Writing a mask to the clear register clears exactly the flags whose mask bits are 1. Writing back a value read from the status register clears all the flags in that value.
- R7: If an edge is detected on a line in the same cycle that a clear write names that line, the flag stays set.
- R8: When a write changes the polarity or select field of an enabled line, that line sets no flag because of the change. Detection resumes afterwards.
- R9: A line whose bit in LINE_MASK is 0 reads zero in the enable, polarity, select and status registers, ignores writes and never flags.
- R10: wake_req is the OR of all flags. wake_irq equals the value wake_req had one clock earlier.
- R11: Register addresses: 0 enable (bit n = line n), 1 polarity (bit n, 0 = rising, 1 = falling), 2 select (line n at bits 2n+1:2n), 3 status (read only), 4 clear (write only, reads zero). Bits above the fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 2*NUM_LINES | Write data |
| reg_rdata | output | 2*NUM_LINES | Read data for reg_addr (combinational) |
| wake_cand | input | 4*NUM_LINES | Raw wake-up candidate signals, four per line |
| wake_flags | output | NUM_LINES | Per-line latched wake-up flags |
| wake_req | output | 1 | OR of all flags |
| wake_irq | output | 1 | Interrupt, wake_req delayed one clock |

## Verification
Two functions can meet in one cycle: setting a flag from a detected edge, and clearing it through the clear register. The bench counts the clocks from a candidate change, so that the clear write is sampled on the same clock edge that would set the flag. It then expects the flag on that line to stay set while another line named in the same mask is cleared. A second meeting is a configuration write that would move the watched level. That case is provoked by changing the select and the polarity toward a candidate of opposite level, and it is judged by the absence of any flag followed by normal detection of a later edge.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

    typedef enum logic [1:0] {
        LN_OFF   = 2'd0,
        LN_PRIME = 2'd1,
        LN_WATCH = 2'd2
    } line_state_e;

    localparam logic [2:0] A_ENABLE = 3'd0;
    localparam logic [2:0] A_POLAR  = 3'd1;
    localparam logic [2:0] A_SELECT = 3'd2;
    localparam logic [2:0] A_STATUS = 3'd3;
    localparam logic [2:0] A_CLEAR  = 3'd4;

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/wkup_line.sv
module wkup_line
    import wkup_pkg::*;
#(
    parameter int SEL_W   = 2,
    parameter bit PRESENT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_wr,
    input  logic                    en_bit,
    input  logic                    pol_wr,
    input  logic                    pol_bit,
    input  logic                    sel_wr,
    input  logic [SEL_W-1:0]        sel_bits,
    input  logic [(1<<SEL_W)-1:0]   cand_sync,
    input  logic                    clr,
    output logic                    en_o,
    output logic                    pol_o,
    output logic [SEL_W-1:0]        sel_o,
    output logic                    flag_o
);

    generate
        if (PRESENT) begin : g_on
            line_state_e      state_q, state_d;
            logic             en_q, pol_q;
            logic [SEL_W-1:0] sel_q;
            logic             prev_q, flag_q;
            logic             cfg_chg, turn_off, lvl, hit;

            // configuration fields
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q  <= 1'b0;
                    pol_q <= 1'b0;
                    sel_q <= '0;
                end else begin
                    if (en_wr)  en_q  <= en_bit;
                    if (pol_wr) pol_q <= pol_bit;
                    if (sel_wr) sel_q <= sel_bits;
                end
            end

            assign cfg_chg  = (pol_wr && (pol_bit != pol_q)) ||
                              (sel_wr && (sel_bits != sel_q));
            assign turn_off = en_wr && !en_bit;

            // next state
            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    LN_OFF: begin
                        if (en_wr && en_bit) state_d = LN_PRIME;
                    end
                    LN_PRIME: begin
                        if (turn_off)     state_d = LN_OFF;
                        else if (cfg_chg) state_d = LN_PRIME;
                        else              state_d = LN_WATCH;
                    end
                    LN_WATCH: begin
                        if (turn_off)     state_d = LN_OFF;
                        else if (cfg_chg) state_d = LN_PRIME;
                    end
                    default: state_d = LN_OFF;
                endcase
            end

            // state register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= LN_OFF;
                else        state_q <= state_d;
            end

            // level seen through the selected source and polarity
            assign lvl = cand_sync[sel_q] ^ pol_q;
            assign hit = (state_q == LN_WATCH) && lvl && !prev_q;

            // outputs: reference level and flag, set has priority
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= 1'b0;
                    flag_q <= 1'b0;
                end else begin
                    prev_q <= lvl;
                    if (hit)      flag_q <= 1'b1;
                    else if (clr) flag_q <= 1'b0;
                end
            end

            assign en_o   = en_q;
            assign pol_o  = pol_q;
            assign sel_o  = sel_q;
            assign flag_o = flag_q;
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst_n, en_wr, en_bit, pol_wr, pol_bit,
                                     sel_wr, sel_bits, cand_sync, clr};
            assign en_o   = 1'b0;
            assign pol_o  = 1'b0;
            assign sel_o  = '0;
            assign flag_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/wkup_line_ctrl.sv
module wkup_line_ctrl
    import wkup_pkg::*;
#(
    parameter int                   NUM_LINES   = 8,
    parameter logic [NUM_LINES-1:0] LINE_MASK   = '1,
    parameter int                   SEL_W       = 2,
    parameter int                   SYNC_STAGES = 2,
    parameter int                   CAND_PER    = 1 << SEL_W,
    parameter int                   CAND_W      = NUM_LINES * CAND_PER,
    parameter int                   DATA_W      = NUM_LINES * SEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [CAND_W-1:0]    wake_cand,
    output logic [NUM_LINES-1:0] wake_flags,
    output logic                 wake_req,
    output logic                 wake_irq
);

    logic                 wr_en, wr_pol, wr_sel, wr_clr;
    logic [CAND_W-1:0]    cand_s;
    logic [NUM_LINES-1:0] en_vec, pol_vec, flag_vec;
    logic [DATA_W-1:0]    sel_vec;
    logic                 irq_q;

    assign wr_en  = reg_wr && (reg_addr == A_ENABLE);
    assign wr_pol = reg_wr && (reg_addr == A_POLAR);
    assign wr_sel = reg_wr && (reg_addr == A_SELECT);
    assign wr_clr = reg_wr && (reg_addr == A_CLEAR);

    wkup_sync #(.W(CAND_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_cand),
        .q     (cand_s)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        wkup_line #(.SEL_W(SEL_W), .PRESENT(LINE_MASK[n])) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_wr     (wr_en),
            .en_bit    (reg_wdata[n]),
            .pol_wr    (wr_pol),
            .pol_bit   (reg_wdata[n]),
            .sel_wr    (wr_sel),
            .sel_bits  (reg_wdata[n*SEL_W +: SEL_W]),
            .cand_sync (cand_s[n*CAND_PER +: CAND_PER]),
            .clr       (wr_clr && reg_wdata[n]),
            .en_o      (en_vec[n]),
            .pol_o     (pol_vec[n]),
            .sel_o     (sel_vec[n*SEL_W +: SEL_W]),
            .flag_o    (flag_vec[n])
        );
    end

    always_comb begin
        case (reg_addr)
            A_ENABLE: reg_rdata = DATA_W'(en_vec);
            A_POLAR:  reg_rdata = DATA_W'(pol_vec);
            A_SELECT: reg_rdata = sel_vec;
            A_STATUS: reg_rdata = DATA_W'(flag_vec);
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |flag_vec;
    end

    assign wake_flags = flag_vec;
    assign wake_req   = |flag_vec;
    assign wake_irq   = irq_q;

endmodule

// File: rtl/wkup_line_ctrl_chk.sv
module wkup_line_ctrl_chk
    import wkup_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [2:0]           reg_addr,
    input logic [NUM_LINES-1:0] wake_flags,
    input logic [NUM_LINES-1:0] en_vec,
    input logic                 wake_req,
    input logic                 wake_irq
);

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |=> wake_irq);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wake_req) |=> !wake_irq);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr && (reg_addr == A_CLEAR)) |->
            ((wake_flags & $past(wake_flags)) == $past(wake_flags)));

    // R5
    off_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wake_flags & ~$past(wake_flags) & ~$past(en_vec)) == '0));

endmodule

bind wkup_line_ctrl wkup_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wake_flags (wake_flags),
    .en_vec     (en_vec),
    .wake_req   (wake_req),
    .wake_irq   (wake_irq)
);

// File: tb/sim_wkup_line_ctrl.sv
module sim_wkup_line_ctrl;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [31:0] wake_cand = 32'h0;
    logic [7:0]  wake_flags;
    logic        wake_req, wake_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    wkup_line_ctrl #(.NUM_LINES(N), .LINE_MASK(8'hDB)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_cand(wake_cand),
        .wake_flags(wake_flags), .wake_req(wake_req), .wake_irq(wake_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cand(input int i, input logic v);
        @(negedge clk);
        wake_cand[i] = v;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 reg after reset", 32'(d), 32'h0);
        end
        check("R1 flags", 32'(wake_flags), 32'h0);
        check("R1 req/irq", {30'h0, wake_req, wake_irq}, 32'h0);
    endtask

    task automatic t_regmap;
        logic [15:0] d;
        wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R9 R11 enable map", 32'(d), 32'h00DB);
        wr(3'd1, 16'hFFFF); rd(3'd1, d); check("R9 R11 polarity map", 32'(d), 32'h00DB);
        wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R9 R11 select map", 32'(d), 32'hF3CF);
        rd(3'd4, d); check("R11 clear reads zero", 32'(d), 32'h0);
        wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h0);
        idle(4);
        check("R5 no flag while off", 32'(wake_flags), 32'h0);
    endtask

    task automatic t_rise;
        logic [15:0] d;
        wr(3'd0, 16'h0001);
        idle(4);
        cand(0, 1'b1);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2 not before third edge", 32'(wake_flags), 32'h0);
        @(posedge clk); @(negedge clk);
        check("R2 flag at third edge", 32'(wake_flags), 32'h01);
        check("R10 req high irq still low", {30'h0, wake_req, wake_irq}, 32'h2);
        @(negedge clk);
        check("R10 irq follows", 32'(wake_irq), 32'h1);
        rd(3'd3, d); check("R11 status read", 32'(d), 32'h01);
        wr(3'd4, 16'h0001);
        @(negedge clk);
        check("R6 cleared", {wake_flags, wake_req, wake_irq}, 32'h001);
        @(negedge clk);
        check("R10 irq drops", 32'(wake_irq), 32'h0);
    endtask

    task automatic t_fall;
        wr(3'd1, 16'h0002);
        wr(3'd0, 16'h0003);
        idle(4);
        cand(4, 1'b1); idle(5);
        check("R3 rising ignored", 32'(wake_flags), 32'h0);
        cand(4, 1'b0); idle(5);
        check("R3 falling flags", 32'(wake_flags), 32'h02);
        wr(3'd4, 16'h0002); idle(1);
        check("R6 line1 cleared", 32'(wake_flags), 32'h0);
    endtask

    task automatic t_select;
        wr(3'd2, 16'h0080);
        wr(3'd0, 16'h000B);
        idle(4);
        cand(12, 1'b1); idle(5);
        check("R4 unselected candidate ignored", 32'(wake_flags), 32'h0);
        cand(14, 1'b1); idle(5);
        check("R4 selected candidate flags", 32'(wake_flags), 32'h08);
        wr(3'd4, 16'h0008); idle(1);
    endtask

    task automatic t_disable;
        logic [15:0] d;
        cand(4, 1'b1); idle(4); cand(4, 1'b0); idle(5);
        check("R3 line1 flag", 32'(wake_flags), 32'h02);
        wr(3'd0, 16'h0009);
        idle(2);
        check("R5 flag kept after disable", 32'(wake_flags), 32'h02);
        rd(3'd1, d); check("R5 polarity kept", 32'(d), 32'h0002);
        rd(3'd2, d); check("R5 select kept", 32'(d), 32'h0080);
        wr(3'd4, 16'h0002);
        cand(4, 1'b1); idle(4); cand(4, 1'b0); idle(5);
        check("R5 disabled line silent", 32'(wake_flags), 32'h0);
    endtask

    task automatic t_collide;
        logic [15:0] d;
        cand(0, 1'b0); idle(4); cand(0, 1'b1); idle(5);
        cand(14, 1'b0); idle(4); cand(14, 1'b1); idle(5);
        check("R2 R4 two flags", 32'(wake_flags), 32'h09);
        cand(0, 1'b0); idle(5);
        cand(0, 1'b1);
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0009;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 set beats clear, R6 other cleared", 32'(wake_flags), 32'h01);
        rd(3'd3, d);
        wr(3'd4, d);
        idle(1);
        check("R6 read-back clear", 32'(wake_flags), 32'h0);
    endtask

    task automatic t_cfgchg;
        cand(0, 1'b0); cand(1, 1'b1); idle(5);
        check("R8 baseline", 32'(wake_flags), 32'h0);
        wr(3'd2, 16'h0081); idle(5);
        check("R8 select change no flag", 32'(wake_flags), 32'h0);
        wr(3'd1, 16'h0003); idle(4);
        wr(3'd1, 16'h0002); idle(5);
        check("R8 polarity change no flag", 32'(wake_flags), 32'h0);
        cand(1, 1'b0); idle(4); cand(1, 1'b1); idle(5);
        check("R8 detection resumes", 32'(wake_flags), 32'h01);
        wr(3'd4, 16'h0001); idle(1);
    endtask

    task automatic t_absent;
        wr(3'd0, 16'h00FF);
        idle(4);
        for (int k = 0; k < 4; k++) begin
            cand(8 + k, 1'b1); cand(20 + k, 1'b1);
        end
        idle(5);
        for (int k = 0; k < 4; k++) begin
            cand(8 + k, 1'b0); cand(20 + k, 1'b0);
        end
        idle(5);
        check("R9 absent lines never flag", 32'(wake_flags), 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        t_reset;
        t_regmap;
        t_rise;
        t_fall;
        t_select;
        t_disable;
        t_collide;
        t_cfgchg;
        t_absent;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule